// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural register, the tag of the reservation station that will produce the newest outstanding value for it. It also holds the register file values. An empty marker (tag 0) means no write is outstanding, so the stored register value is current. The reservation stations themselves are outside the block.

A dispatch names two source registers, one destination register and the tag of the station just allocated. In the same cycle the block answers each source lookup combinationally. The answer is either a ready value or the tag of the station to wait for. At the clock edge the destination entry is pointed at the new tag.

A result broadcast carries a station tag, the destination register and the data. The value is committed to the register file, and the entry is cleared, only if the entry still holds that same tag. This drops results from producers that a younger rename has overtaken.

Top module: `rename_status_table`

## Requirements
- R1: After reset every entry is empty (tag 0) and every register value is 0, so each source lookup returns ready with value 0.
- R2: A source whose entry is empty, with no committing broadcast to it in that cycle, returns ready=1, tag=0 and the stored register value.
- R3: A source whose entry holds a nonzero tag, with no committing broadcast to it, returns ready=0, value 0 and that tag on the tag output.
- R4: A dispatch writes its tag into the destination entry from the next cycle on, replacing any older tag.
- R5: A broadcast whose tag is nonzero and equals the destination's current entry writes the data into that register and empties the entry from the next cycle on.
- R6: A broadcast whose tag differs from the destination's current entry changes neither the register value nor the entry.
- R7: A broadcast with tag 0 is ignored: no register, no entry and no lookup is affected.
- R8: When the destination of a dispatch is also one of its sources, the source lookup uses the entry as it was before this dispatch.
- R9: A source that names the register of a committing broadcast in the same cycle returns ready=1, tag=0 and the broadcast data.
- R10: When a committing broadcast and a dispatch target the same register in the same cycle, the entry takes the dispatch tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch this cycle; renames the destination |
| disp_src_a_i | input | 5 | First source register |
| disp_src_b_i | input | 5 | Second source register |
| disp_dst_i | input | 5 | Destination register to rename |
| disp_tag_i | input | 4 | Allocated station tag, nonzero |
| bc_valid_i | input | 1 | Result broadcast this cycle |
| bc_dst_i | input | 5 | Destination register of the broadcast result |
| bc_tag_i | input | 4 | Station tag of the broadcast result |
| bc_data_i | input | 32 | Broadcast result value |
| src_a_ready_o | output | 1 | First source value is available |
| src_a_tag_o | output | 4 | Producer to wait for (0 when ready) |
| src_a_value_o | output | 32 | First source value (0 when not ready) |
| src_b_ready_o | output | 1 | Second source value is available |
| src_b_tag_o | output | 4 | Producer to wait for (0 when ready) |
| src_b_value_o | output | 32 | Second source value (0 when not ready) |

## Verification
A corrupt entry appears the next time that register is looked up. A lost rename shows up as a stale ready value. A lost clear leaves the register waiting on a tag that will never broadcast again. A broadcast that wrongly commits while its entry has been superseded writes a value that no port shows at first. It appears only once the younger producer's broadcast is dropped or misordered, so the bench issues two renames before each pair of broadcasts and reads the register back in between. A reference model of the table and the register file is checked against both lookup ports in every cycle of a random phase.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam int unsigned DEF_NREG   = 32;
  localparam int unsigned DEF_TAG_W  = 4;
  localparam int unsigned DEF_DATA_W = 32;

  typedef enum logic [1:0] {
    SRC_FILE,
    SRC_BYPASS,
    SRC_WAIT
  } src_sel_e;
endpackage

// File: rtl/rst_map_table.sv
module rst_map_table #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned TAG_W = 4,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ren_en_i,
  input  logic [IDX_W-1:0]           ren_idx_i,
  input  logic [TAG_W-1:0]           ren_tag_i,
  input  logic                       clr_en_i,
  input  logic [IDX_W-1:0]           clr_idx_i,
  output logic [NREG-1:0][TAG_W-1:0] map_o
);
  for (genvar e = 0; e < NREG; e++) begin : g_entry
    logic ren_hit, clr_hit;
    assign ren_hit = ren_en_i && (ren_idx_i == IDX_W'(e));
    assign clr_hit = clr_en_i && (clr_idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      map_o[e] <= '0;
      else if (ren_hit) map_o[e] <= ren_tag_i;  // rename wins over clear
      else if (clr_hit) map_o[e] <= '0;
    end
  end
endmodule

// File: rtl/rst_reg_file.sv
module rst_reg_file #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output logic [NREG-1:0][DATA_W-1:0] rf_o
);
  for (genvar e = 0; e < NREG; e++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rf_o[e] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(e))) rf_o[e] <= wr_data_i;
    end
  end
endmodule

// File: rtl/rst_src_lookup.sv
module rst_src_lookup
  import rst_pkg::*;
#(
  parameter int unsigned NREG   = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0][TAG_W-1:0]  map_i,
  input  logic [NREG-1:0][DATA_W-1:0] rf_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic                        bc_commit_i,
  input  logic [IDX_W-1:0]            bc_idx_i,
  input  logic [DATA_W-1:0]           bc_data_i,
  output logic                        ready_o,
  output logic [TAG_W-1:0]            tag_o,
  output logic [DATA_W-1:0]           value_o
);
  src_sel_e         sel;
  logic [TAG_W-1:0] pend;

  always_comb begin
    pend = map_i[idx_i];
    if (bc_commit_i && (bc_idx_i == idx_i)) sel = SRC_BYPASS;
    else if (pend == '0)                     sel = SRC_FILE;
    else                                     sel = SRC_WAIT;
  end

  always_comb begin
    ready_o = 1'b1;
    tag_o   = '0;
    value_o = '0;
    unique case (sel)
      SRC_BYPASS: value_o = bc_data_i;
      SRC_FILE:   value_o = rf_i[idx_i];
      default: begin
        ready_o = 1'b0;
        tag_o   = pend;
      end
    endcase
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rst_pkg::*;
#(
  parameter int unsigned NREG   = DEF_NREG,
  parameter int unsigned TAG_W  = DEF_TAG_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned NSRC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [IDX_W-1:0]  disp_src_a_i,
  input  logic [IDX_W-1:0]  disp_src_b_i,
  input  logic [IDX_W-1:0]  disp_dst_i,
  input  logic [TAG_W-1:0]  disp_tag_i,
  input  logic              bc_valid_i,
  input  logic [IDX_W-1:0]  bc_dst_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              src_a_ready_o,
  output logic [TAG_W-1:0]  src_a_tag_o,
  output logic [DATA_W-1:0] src_a_value_o,
  output logic              src_b_ready_o,
  output logic [TAG_W-1:0]  src_b_tag_o,
  output logic [DATA_W-1:0] src_b_value_o
);
  logic [NREG-1:0][TAG_W-1:0]  map_q;
  logic [NREG-1:0][DATA_W-1:0] rf_q;
  logic                        commit;

  // only the still-current producer may retire its value
  assign commit = bc_valid_i && (bc_tag_i != '0) && (map_q[bc_dst_i] == bc_tag_i);

  rst_map_table #(.NREG(NREG), .TAG_W(TAG_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ren_en_i  (disp_valid_i),
    .ren_idx_i (disp_dst_i),
    .ren_tag_i (disp_tag_i),
    .clr_en_i  (commit),
    .clr_idx_i (bc_dst_i),
    .map_o     (map_q)
  );

  rst_reg_file #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (commit),
    .wr_idx_i  (bc_dst_i),
    .wr_data_i (bc_data_i),
    .rf_o      (rf_q)
  );

  logic [NSRC-1:0][IDX_W-1:0]  src_idx;
  logic [NSRC-1:0]             src_rdy;
  logic [NSRC-1:0][TAG_W-1:0]  src_tag;
  logic [NSRC-1:0][DATA_W-1:0] src_val;

  assign src_idx[0] = disp_src_a_i;
  assign src_idx[1] = disp_src_b_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    rst_src_lookup #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lk (
      .map_i       (map_q),
      .rf_i        (rf_q),
      .idx_i       (src_idx[s]),
      .bc_commit_i (commit),
      .bc_idx_i    (bc_dst_i),
      .bc_data_i   (bc_data_i),
      .ready_o     (src_rdy[s]),
      .tag_o       (src_tag[s]),
      .value_o     (src_val[s])
    );
  end

  assign src_a_ready_o = src_rdy[0];
  assign src_a_tag_o   = src_tag[0];
  assign src_a_value_o = src_val[0];
  assign src_b_ready_o = src_rdy[1];
  assign src_b_tag_o   = src_tag[1];
  assign src_b_value_o = src_val[1];
endmodule

// File: rtl/rst_checker.sv
module rst_checker #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        disp_valid_i,
  input logic [IDX_W-1:0]            disp_src_a_i,
  input logic [IDX_W-1:0]            disp_dst_i,
  input logic [TAG_W-1:0]            disp_tag_i,
  input logic                        bc_valid_i,
  input logic [IDX_W-1:0]            bc_dst_i,
  input logic [TAG_W-1:0]            bc_tag_i,
  input logic [DATA_W-1:0]           bc_data_i,
  input logic                        src_a_ready_o,
  input logic [TAG_W-1:0]            src_a_tag_o,
  input logic [DATA_W-1:0]           src_a_value_o,
  input logic [NREG-1:0][TAG_W-1:0]  map_q,
  input logic [NREG-1:0][DATA_W-1:0] rf_q
);
  logic hit, same_reg;
  assign hit      = bc_valid_i && (bc_tag_i != '0) && (map_q[bc_dst_i] == bc_tag_i);
  assign same_reg = disp_valid_i && (disp_dst_i == bc_dst_i);

  // R4
  rename_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i |=> map_q[$past(disp_dst_i)] == $past(disp_tag_i));

  // R4
  tag_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i |-> disp_tag_i != '0);

  // R5
  commit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !same_reg) |=> (map_q[$past(bc_dst_i)] == '0) &&
                           (rf_q[$past(bc_dst_i)] == $past(bc_data_i)));

  // R6
  stale_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_valid_i && map_q[bc_dst_i] != bc_tag_i && !same_reg)
      |=> (rf_q[$past(bc_dst_i)] == $past(rf_q[bc_dst_i])) &&
          (map_q[$past(bc_dst_i)] == $past(map_q[bc_dst_i])));

  // R7
  zero_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_valid_i && bc_tag_i == '0 && !disp_valid_i) |=> $stable(rf_q) && $stable(map_q));

  // R9
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && disp_src_a_i == bc_dst_i) |-> src_a_ready_o && (src_a_value_o == bc_data_i));

  // R3
  wait_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_q[disp_src_a_i] != '0 && !(hit && disp_src_a_i == bc_dst_i))
      |-> !src_a_ready_o && (src_a_tag_o == map_q[disp_src_a_i]));
endmodule

bind rename_status_table rst_checker #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .disp_valid_i  (disp_valid_i),
  .disp_src_a_i  (disp_src_a_i),
  .disp_dst_i    (disp_dst_i),
  .disp_tag_i    (disp_tag_i),
  .bc_valid_i    (bc_valid_i),
  .bc_dst_i      (bc_dst_i),
  .bc_tag_i      (bc_tag_i),
  .bc_data_i     (bc_data_i),
  .src_a_ready_o (src_a_ready_o),
  .src_a_tag_o   (src_a_tag_o),
  .src_a_value_o (src_a_value_o),
  .map_q         (map_q),
  .rf_q          (rf_q)
);

// File: tb/rename_status_table_test.sv
module rename_status_table_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        disp_valid_i = 1'b0;
  logic [4:0]  disp_src_a_i = '0, disp_src_b_i = '0, disp_dst_i = '0;
  logic [3:0]  disp_tag_i = '0;
  logic        bc_valid_i = 1'b0;
  logic [4:0]  bc_dst_i = '0;
  logic [3:0]  bc_tag_i = '0;
  logic [31:0] bc_data_i = '0;
  logic        src_a_ready_o, src_b_ready_o;
  logic [3:0]  src_a_tag_o, src_b_tag_o;
  logic [31:0] src_a_value_o, src_b_value_o;

  always #4 clk = ~clk;  // 125 MHz

  rename_status_table uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid_i), .disp_src_a_i(disp_src_a_i), .disp_src_b_i(disp_src_b_i),
    .disp_dst_i(disp_dst_i), .disp_tag_i(disp_tag_i),
    .bc_valid_i(bc_valid_i), .bc_dst_i(bc_dst_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
    .src_a_ready_o(src_a_ready_o), .src_a_tag_o(src_a_tag_o), .src_a_value_o(src_a_value_o),
    .src_b_ready_o(src_b_ready_o), .src_b_tag_o(src_b_tag_o), .src_b_value_o(src_b_value_o)
  );

  typedef struct {
    logic        rdy;
    logic [3:0]  tag;
    logic [31:0] val;
    string       lbl;
  } exp_t;

  exp_t        sb_q[$];
  event        sample_ev;
  int          checks = 0, fails = 0;
  logic [3:0]  m_map[32];
  logic [31:0] m_rf[32];

  function automatic exp_t predict(int src, bit bv, int bd, int bt, logic [31:0] bdat, string lbl);
    exp_t e;
    e.lbl = lbl;
    if (bv && bt != 0 && bd == src && m_map[bd] == 4'(bt)) begin
      e.rdy = 1; e.tag = 0; e.val = bdat;
    end else if (m_map[src] == 0) begin
      e.rdy = 1; e.tag = 0; e.val = m_rf[src];
    end else begin
      e.rdy = 0; e.tag = m_map[src]; e.val = 0;
    end
    return e;
  endfunction

  task automatic step(bit dv, int da, int db, int dd, int dt,
                      bit bv, int bd, int bt, logic [31:0] bdat, string lbl);
    @(negedge clk);
    disp_valid_i = dv; disp_src_a_i = 5'(da); disp_src_b_i = 5'(db);
    disp_dst_i = 5'(dd); disp_tag_i = 4'(dt);
    bc_valid_i = bv; bc_dst_i = 5'(bd); bc_tag_i = 4'(bt); bc_data_i = bdat;
    sb_q.push_back(predict(da, bv, bd, bt, bdat, lbl));
    sb_q.push_back(predict(db, bv, bd, bt, bdat, lbl));
    -> sample_ev;
    if (bv && bt != 0 && m_map[bd] == 4'(bt)) begin
      m_rf[bd] = bdat;
      m_map[bd] = 0;
    end
    if (dv) m_map[dd] = 4'(dt);
  endtask

  task automatic compare(exp_t e, logic r, logic [3:0] t, logic [31:0] v, string port);
    checks++;
    if (r !== e.rdy || t !== e.tag || v !== e.val) begin
      fails++;
      $display("FAIL %s port %s: got rdy=%0b tag=%0d val=%h, expected rdy=%0b tag=%0d val=%h",
               e.lbl, port, r, t, v, e.rdy, e.tag, e.val);
    end
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      #1;
      compare(sb_q.pop_front(), src_a_ready_o, src_a_tag_o, src_a_value_o, "a");
      compare(sb_q.pop_front(), src_b_ready_o, src_b_tag_o, src_b_value_o, "b");
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : driver
    for (int i = 0; i < 32; i++) begin m_map[i] = 0; m_rf[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state of every register
    for (int i = 0; i < 16; i++) step(0, 2*i, 2*i+1, 0, 0, 0, 0, 0, 0, "R1 reset");
    // R4 then R3
    step(1, 5, 6, 5, 3, 0, 0, 0, 0, "R4 rename");
    step(0, 5, 6, 0, 0, 0, 0, 0, 0, "R3 pending");
    // R9 same-cycle bypass, then R5 commit
    step(0, 5, 6, 0, 0, 1, 5, 3, 32'h0000_1234, "R9 bypass");
    step(0, 5, 6, 0, 0, 0, 0, 0, 0, "R5 commit");
    // R6 overtaken producer
    step(1, 0, 0, 7, 2, 0, 0, 0, 0, "R4 first");
    step(1, 7, 0, 7, 4, 0, 0, 0, 0, "R4 second");
    step(0, 7, 0, 0, 0, 1, 7, 2, 32'h0000_AAAA, "R6 stale bc");
    step(0, 7, 5, 0, 0, 0, 0, 0, 0, "R6 after stale");
    step(0, 0, 0, 0, 0, 1, 7, 4, 32'h0000_BBBB, "R5 young bc");
    step(0, 7, 0, 0, 0, 0, 0, 0, 0, "R5 young value");
    // R7 zero tag
    step(0, 8, 0, 0, 0, 1, 8, 0, 32'h0000_DEAD, "R7 zero tag");
    step(0, 8, 0, 0, 0, 0, 0, 0, 0, "R7 after");
    // R8 source equals destination
    step(1, 5, 7, 5, 6, 0, 0, 0, 0, "R8 self source");
    step(0, 5, 0, 0, 0, 0, 0, 0, 0, "R8 after");
    // R10 rename and clear collide
    step(1, 5, 0, 5, 9, 1, 5, 6, 32'h0000_5555, "R10 collide");
    step(0, 5, 0, 0, 0, 0, 0, 0, 0, "R10 after");
    step(0, 0, 0, 0, 0, 1, 5, 9, 32'h0000_7777, "R5 final bc");
    step(0, 5, 0, 0, 0, 0, 0, 0, 0, "R5 final");
    // R2 R3 mixed traffic against model
    for (int n = 0; n < 600; n++) begin
      int bd, bt;
      bd = int'($urandom_range(0, 31));
      bt = ($urandom_range(0, 3) != 0) ? int'(m_map[bd]) : int'($urandom_range(0, 15));
      step($urandom_range(0, 1) == 1, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
           int'($urandom_range(0, 31)), int'($urandom_range(1, 15)),
           $urandom_range(0, 1) == 1, bd, bt, $urandom, "R2 R3 mix");
    end
    @(negedge clk);
    #2;
    finish_run();
  end
endmodule